// File: doc/BRIEF.md
# HDMI Receiver Reset Domain Controller

This block decides when each sub-domain of a four-input HDMI receiver is held in reset. It watches the chip reset pin, the core supply-good level, the TMDS clock-activity and 5 V cable-detect lines of every input, the input selector, the DVI/HDMI mode and two control bits. From these it drives four independent domain resets: the main HDMI section, the audio section, the packet processor with its InfoFrame store, and the EDID/repeater controller. It also drives a one-cycle strobe that clears the packet detection flags.

The domains differ in what resets them. The EDID/repeater controller keeps its state through a chip reset and is reset only by a supply dropout or by its own software bit. The packet processor is also held in reset for as long as the stream is DVI. Events that only mean "new source" clear the detection flags without resetting any domain. These events are a newly rising 5 V detect, a change of input and a returning TMDS clock.

The clock-activity, 5 V and supply-good inputs are asynchronous and each passes through a two-flop synchronizer. The other inputs are taken as synchronous to `clk`.

Top module: `hdmi_rx_rst_ctrl`

## Requirements
- R1: While `chip_rst_n` is low, `hdmi_rst`, `aud_rst` and `pkt_rst` are 1 and `flag_clr` is 0. These resets assert as soon as the pin falls, without waiting for a clock edge. `edid_rst` is not affected by the pin.
- R2: If the TMDS activity input of the selected port is 0 after synchronization, `hdmi_rst` and `aud_rst` are asserted. An input reaches the decision logic two clock edges after it is sampled.
- R3: If the 5 V detect of the selected port is 0, `hdmi_rst` and `aud_rst` are asserted, except while `cable_rst_dis` is 1. In that case the missing 5 V has no effect.
- R4: Each domain reset stays asserted while its cause is present and for exactly 4 (HOLD) further clock cycles after the cause clears. The same applies after `chip_rst_n` returns high. Release happens on a rising clock edge.
- R5: `pkt_rst` is asserted whenever `hdmi_rst` is, and also in the cycle after any cycle in which `dvi_mode` is 1.
- R6: `edid_rst` is asserted when the synchronized `supply_good` is 0 or when `edid_sw_rst` is 1, with the same 4-cycle hold. Chip reset, clock loss and 5 V loss do not affect it. It starts asserted at power-up.
- R7: `flag_clr` pulses for one cycle in any of these cases: the first cycle after chip reset release; a rise of the synchronized `supply_good`; any change of `port_sel` from the previous cycle; a rise of the selected port's TMDS activity; or a rise of the selected port's 5 V detect. The 5 V rise is ignored while `cable_rst_dis` is 1.
- R8: `flag_clr` is never 1 in two consecutive cycles. A trigger that arrives in the cycle right after a pulse is merged into that pulse.
- R9: `port_sel` values 0, 1, 2 and 3 select ports A, B, C and D, which are bits 0, 1, 2 and 3 of `tmds_act` and `cable_5v`. Values 4 to 7 select no port and are treated as no TMDS clock and no 5 V.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receiver clock |
| chip_rst_n | input | 1 | Chip reset pin, active low, asynchronous assertion |
| supply_good | input | 1 | Core digital supply good, asynchronous |
| tmds_act | input | NPORTS | Per-port TMDS clock activity, asynchronous, bit 0 = port A |
| cable_5v | input | NPORTS | Per-port 5 V detect, asynchronous, bit 0 = port A |
| port_sel | input | SEL_W | Input selector, 0..3 = A..D |
| dvi_mode | input | 1 | 1 while the incoming stream is DVI |
| cable_rst_dis | input | 1 | 1 disables the 5 V loss reset and the 5 V rise flag clear |
| edid_sw_rst | input | 1 | Software reset of the EDID/repeater controller |
| hdmi_rst | output | 1 | Main HDMI section reset, active high |
| aud_rst | output | 1 | Audio section reset, active high |
| pkt_rst | output | 1 | Packet processor and InfoFrame store reset, active high |
| edid_rst | output | 1 | EDID/repeater controller reset, active high |
| flag_clr | output | 1 | One-cycle strobe that clears the packet detection flags |

## Verification
The properties assume that `dvi_mode`, `edid_sw_rst`, `port_sel` and `cable_rst_dis` change only between rising edges of `clk`. They also assume that `chip_rst_n` never rises in the same instant as a clock edge. The bench meets both by driving every input on the falling edge, including the asynchronous activity, 5 V and supply lines. A check taken just after a falling edge of `chip_rst_n` confirms that the resets assert without waiting for a clock. The random phase keeps input selections mostly within A–D, with occasional selections of the unused codes 4–7.

// File: rtl/hdmi_rx_rst_pkg.sv
package hdmi_rx_rst_pkg;

  // Index of each reset domain in the domain vectors
  typedef enum int {
    DOM_HDMI = 0,
    DOM_AUD  = 1,
    DOM_PKT  = 2,
    DOM_EDID = 3
  } rst_dom_e;

  localparam int NUM_DOMS = 4;

  // Events that clear the packet detection flags (boot is tracked separately)
  typedef struct packed {
    logic supply_up;
    logic port_moved;
    logic clk_back;
    logic cable_up;
  } clr_src_t;

  function automatic logic any_src(input clr_src_t s);
    return |s;
  endfunction

endpackage

// File: rtl/hdmi_rx_rst_sync.sv
module hdmi_rx_rst_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);

  // Free-running chain: no reset, so supply loss is seen even during chip reset
  logic [STAGES-1:0][W-1:0] chain = '0;

  always_ff @(posedge clk) begin
    chain[0] <= d_async;
    for (int i = 1; i < STAGES; i++) begin
      chain[i] <= chain[i-1];
    end
  end

  assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/hdmi_rx_rst_hold.sv
module hdmi_rx_rst_hold #(
  parameter int HOLD      = 4,
  parameter bit ASYNC_SET = 1'b1
) (
  input  logic clk,
  input  logic arst_n,
  input  logic cause,
  output logic rst_o
);

  localparam int            CW     = $clog2(HOLD + 1);
  localparam logic [CW-1:0] HOLD_V = CW'(HOLD);
  localparam logic [CW-1:0] ONE_V  = CW'(1);

  generate
    if (ASYNC_SET) begin : g_async
      logic [CW-1:0] cnt;
      logic          held;

      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
          cnt  <= HOLD_V;
          held <= 1'b1;
        end else if (cause) begin
          cnt  <= HOLD_V;
          held <= 1'b1;
        end else if (cnt != '0) begin
          cnt  <= cnt - ONE_V;
          held <= 1'b1;
        end else begin
          held <= 1'b0;
        end
      end

      assign rst_o = held;
    end else begin : g_sync
      // Domain outside the chip reset: power-up value only
      logic [CW-1:0] cnt  = HOLD_V;
      logic          held = 1'b1;
      logic          unused_arst;

      assign unused_arst = arst_n;

      always_ff @(posedge clk) begin
        if (cause) begin
          cnt  <= HOLD_V;
          held <= 1'b1;
        end else if (cnt != '0) begin
          cnt  <= cnt - ONE_V;
          held <= 1'b1;
        end else begin
          held <= 1'b0;
        end
      end

      assign rst_o = held;
    end
  endgenerate

endmodule

// File: rtl/hdmi_rx_rst_flagclr.sv
module hdmi_rx_rst_flagclr
  import hdmi_rx_rst_pkg::*;
(
  input  logic     clk,
  input  logic     arst_n,
  input  clr_src_t src,
  output logic     pulse
);

  logic boot;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      boot  <= 1'b1;
      pulse <= 1'b0;
    end else begin
      boot  <= 1'b0;
      pulse <= (any_src(src) | boot) & ~pulse;
    end
  end

endmodule

// File: rtl/hdmi_rx_rst_ctrl.sv
module hdmi_rx_rst_ctrl
  import hdmi_rx_rst_pkg::*;
#(
  parameter int NPORTS      = 4,
  parameter int SEL_W       = 3,
  parameter int HOLD        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              chip_rst_n,
  input  logic              supply_good,
  input  logic [NPORTS-1:0] tmds_act,
  input  logic [NPORTS-1:0] cable_5v,
  input  logic [SEL_W-1:0]  port_sel,
  input  logic              dvi_mode,
  input  logic              cable_rst_dis,
  input  logic              edid_sw_rst,
  output logic              hdmi_rst,
  output logic              aud_rst,
  output logic              pkt_rst,
  output logic              edid_rst,
  output logic              flag_clr
);

  localparam int PIDX_W = (NPORTS > 1) ? $clog2(NPORTS) : 1;
  localparam int AW     = 2 * NPORTS + 1;

  // ---------------- synchronizers ----------------
  logic [AW-1:0] raw_async, raw_sync;
  logic [NPORTS-1:0] s_act, s_5v;
  logic              s_sup;

  assign raw_async = {supply_good, cable_5v, tmds_act};

  hdmi_rx_rst_sync #(.W(AW), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .d_async (raw_async),
    .q_sync  (raw_sync)
  );

  assign s_act = raw_sync[NPORTS-1:0];
  assign s_5v  = raw_sync[2*NPORTS-1:NPORTS];
  assign s_sup = raw_sync[AW-1];

  // ---------------- selected port view ----------------
  logic              sel_valid;
  logic [PIDX_W-1:0] sel_idx;
  logic              sel_act, sel_5v;

  assign sel_valid = (int'(port_sel) < NPORTS);
  assign sel_idx   = port_sel[PIDX_W-1:0];

  always_comb begin
    sel_act = 1'b0;
    sel_5v  = 1'b0;
    if (sel_valid) begin
      sel_act = s_act[sel_idx];
      sel_5v  = s_5v[sel_idx];
    end
  end

  // ---------------- history for edge detection (free-running) ----------------
  logic             prev_act  = 1'b0;
  logic             prev_5v   = 1'b0;
  logic             prev_sup  = 1'b0;
  logic [SEL_W-1:0] prev_port = '0;

  always_ff @(posedge clk) begin
    prev_act  <= sel_act;
    prev_5v   <= sel_5v;
    prev_sup  <= s_sup;
    prev_port <= port_sel;
  end

  // ---------------- domain causes ----------------
  logic                link_lost;
  logic [NUM_DOMS-1:0] dom_cause;
  logic [NUM_DOMS-1:0] dom_rst;

  assign link_lost = ~sel_act | (~sel_5v & ~cable_rst_dis);

  always_comb begin
    dom_cause           = '0;
    dom_cause[DOM_HDMI] = link_lost;
    dom_cause[DOM_AUD]  = link_lost;
    dom_cause[DOM_PKT]  = link_lost | dvi_mode;
    dom_cause[DOM_EDID] = ~s_sup | edid_sw_rst;
  end

  generate
    for (genvar d = 0; d < NUM_DOMS; d++) begin : g_dom
      localparam bit IS_EDID = (d == int'(DOM_EDID));
      logic arst_sel;

      assign arst_sel = IS_EDID ? 1'b1 : chip_rst_n;

      hdmi_rx_rst_hold #(.HOLD(HOLD), .ASYNC_SET(!IS_EDID)) u_hold (
        .clk    (clk),
        .arst_n (arst_sel),
        .cause  (dom_cause[d]),
        .rst_o  (dom_rst[d])
      );
    end
  endgenerate

  assign hdmi_rst = dom_rst[DOM_HDMI];
  assign aud_rst  = dom_rst[DOM_AUD];
  assign pkt_rst  = dom_rst[DOM_PKT];
  assign edid_rst = dom_rst[DOM_EDID];

  // ---------------- flag clear strobe ----------------
  clr_src_t clr_src;

  always_comb begin
    clr_src.supply_up  = s_sup & ~prev_sup;
    clr_src.port_moved = (port_sel != prev_port);
    clr_src.clk_back   = sel_act & ~prev_act;
    clr_src.cable_up   = sel_5v & ~prev_5v & ~cable_rst_dis;
  end

  hdmi_rx_rst_flagclr u_flagclr (
    .clk    (clk),
    .arst_n (chip_rst_n),
    .src    (clr_src),
    .pulse  (flag_clr)
  );

endmodule

// File: rtl/hdmi_rx_rst_ctrl_chk.sv
module hdmi_rx_rst_ctrl_chk (
  input logic clk,
  input logic chip_rst_n,
  input logic dvi_mode,
  input logic edid_sw_rst,
  input logic hdmi_rst,
  input logic aud_rst,
  input logic pkt_rst,
  input logic edid_rst,
  input logic flag_clr
);

  // R2: audio and main section share their causes
  p_aud_follows_r2: assert property (@(posedge clk) disable iff (!chip_rst_n)
    aud_rst == hdmi_rst);

  // R5: the packet domain is a superset of the main section
  p_pkt_covers_r5: assert property (@(posedge clk) disable iff (!chip_rst_n)
    hdmi_rst |-> pkt_rst);

  // R5: DVI stream holds the packet processor in reset
  p_dvi_pkt_r5: assert property (@(posedge clk) disable iff (!chip_rst_n)
    dvi_mode |=> pkt_rst);

  // R6: software bit resets the EDID controller
  p_sw_edid_r6: assert property (@(posedge clk) disable iff (!chip_rst_n)
    edid_sw_rst |=> edid_rst);

  // R6: EDID reset never releases right after a software request
  p_edid_release_r6: assert property (@(posedge clk) disable iff (!chip_rst_n)
    $fell(edid_rst) |-> !$past(edid_sw_rst));

  // R8: the strobe is one cycle wide
  p_flag_single_r8: assert property (@(posedge clk) disable iff (!chip_rst_n)
    flag_clr |=> !flag_clr);

endmodule

bind hdmi_rx_rst_ctrl hdmi_rx_rst_ctrl_chk u_chk (
  .clk         (clk),
  .chip_rst_n  (chip_rst_n),
  .dvi_mode    (dvi_mode),
  .edid_sw_rst (edid_sw_rst),
  .hdmi_rst    (hdmi_rst),
  .aud_rst     (aud_rst),
  .pkt_rst     (pkt_rst),
  .edid_rst    (edid_rst),
  .flag_clr    (flag_clr)
);

// File: tb/hdmi_rx_rst_ctrl_tb.sv
module hdmi_rx_rst_ctrl_tb;

  localparam int NP   = 4;
  localparam int SW   = 3;
  localparam int HOLD = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic          chip_rst_n    = 1'b0;
  logic          supply_good   = 1'b0;
  logic [NP-1:0] tmds_act      = '0;
  logic [NP-1:0] cable_5v      = '0;
  logic [SW-1:0] port_sel      = '0;
  logic          dvi_mode      = 1'b0;
  logic          cable_rst_dis = 1'b0;
  logic          edid_sw_rst   = 1'b0;
  logic hdmi_rst, aud_rst, pkt_rst, edid_rst, flag_clr;

  hdmi_rx_rst_ctrl #(.NPORTS(NP), .SEL_W(SW), .HOLD(HOLD), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .chip_rst_n(chip_rst_n), .supply_good(supply_good),
    .tmds_act(tmds_act), .cable_5v(cable_5v), .port_sel(port_sel),
    .dvi_mode(dvi_mode), .cable_rst_dis(cable_rst_dis), .edid_sw_rst(edid_sw_rst),
    .hdmi_rst(hdmi_rst), .aud_rst(aud_rst), .pkt_rst(pkt_rst),
    .edid_rst(edid_rst), .flag_clr(flag_clr)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [NP-1:0] m_a1 = '0, m_a2 = '0, m_v1 = '0, m_v2 = '0;
  bit m_p1 = 0, m_p2 = 0;
  bit pv_act = 0, pv_5v = 0, pv_sup = 0;
  logic [SW-1:0] pv_port = '0;
  int m_ch = HOLD, m_ca = HOLD, m_cp = HOLD, m_ce = HOLD;
  bit m_h = 1, m_a = 1, m_p = 1, m_e = 1, m_f = 0, m_boot = 1;

  task automatic hold_step(input bit cause, ref int c, ref bit o);
    if (cause) begin c = HOLD; o = 1; end
    else if (c != 0) begin c = c - 1; o = 1; end
    else o = 0;
  endtask

  task automatic model_step();
    int pi;
    bit sa, s5, lost, trig;
    pi = int'(port_sel);
    sa = 0; s5 = 0;
    if (pi < NP) begin sa = m_a2[pi]; s5 = m_v2[pi]; end            // R9
    lost = !sa || (!s5 && !cable_rst_dis);                          // R2 R3
    trig = (m_p2 && !pv_sup) || (port_sel != pv_port) ||
           (sa && !pv_act) || (s5 && !pv_5v && !cable_rst_dis);     // R7
    if (!chip_rst_n) begin                                          // R1
      m_h = 1; m_a = 1; m_p = 1; m_ch = HOLD; m_ca = HOLD; m_cp = HOLD;
      m_f = 0; m_boot = 1;
    end else begin
      hold_step(lost, m_ch, m_h);
      hold_step(lost, m_ca, m_a);
      hold_step(lost || dvi_mode, m_cp, m_p);                       // R5
      m_f = (trig || m_boot) && !m_f;                               // R8
      m_boot = 0;
    end
    hold_step(!m_p2 || edid_sw_rst, m_ce, m_e);                     // R6
    pv_act = sa; pv_5v = s5; pv_sup = m_p2; pv_port = port_sel;
    m_a2 = m_a1; m_a1 = tmds_act;
    m_v2 = m_v1; m_v1 = cable_5v;
    m_p2 = m_p1; m_p1 = supply_good;
  endtask

  // Compare on every clock, 2 ns after the edge
  initial begin
    forever begin
      @(posedge clk);
      model_step();
      #2;
      if (!done) begin
        chk("R2/R3/R4", "hdmi_rst", hdmi_rst, m_h);
        chk("R2/R4", "aud_rst", aud_rst, m_a);
        chk("R5/R4", "pkt_rst", pkt_rst, m_p);
        chk("R6", "edid_rst", edid_rst, m_e);
        chk("R7/R8/R9", "flag_clr", flag_clr, m_f);
      end
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R1: asynchronous assertion check just after the pin falls
  task automatic pull_chip_reset(input int len);
    logic e_before;
    @(negedge clk);
    e_before = edid_rst;
    chip_rst_n = 1'b0;
    #1;
    chk("R1", "hdmi_rst immediate", hdmi_rst, 1'b1);
    chk("R1", "aud_rst immediate", aud_rst, 1'b1);
    chk("R1", "pkt_rst immediate", pkt_rst, 1'b1);
    chk("R1", "flag_clr quiet", flag_clr, 1'b0);
    chk("R6", "edid_rst untouched by pin", edid_rst, e_before);
    wait_n(len);
    chip_rst_n = 1'b1;
  endtask

  initial begin
    // reset state: R1 and R6 power-up
    wait_n(3);
    chk("R1", "hdmi_rst in reset", hdmi_rst, 1'b1);
    chk("R6", "edid_rst at power-up", edid_rst, 1'b1);
    supply_good = 1'b1; tmds_act = '1; cable_5v = '1; port_sel = 3'd0;
    wait_n(6);
    chip_rst_n = 1'b1;
    wait_n(12);
    chk("R4", "hdmi_rst released", hdmi_rst, 1'b0);
    chk("R6", "edid_rst released", edid_rst, 1'b0);

    // R2: clock loss on selected port A
    tmds_act[0] = 1'b0; wait_n(3); tmds_act[0] = 1'b1; wait_n(12);
    // R9: clock loss on unselected port B has no effect
    tmds_act[1] = 1'b0; wait_n(6);
    chk("R9", "unselected loss ignored", hdmi_rst, 1'b0);
    tmds_act[1] = 1'b1; wait_n(4);
    // R3: 5 V loss, then its rise clears the flags (R7)
    cable_5v[0] = 1'b0; wait_n(4); cable_5v[0] = 1'b1; wait_n(12);
    // R3: with disable bit the 5 V loss and rise are ignored
    cable_rst_dis = 1'b1; cable_5v[0] = 1'b0; wait_n(6);
    chk("R3", "5V loss ignored when disabled", hdmi_rst, 1'b0);
    cable_5v[0] = 1'b1; wait_n(6); cable_rst_dis = 1'b0; wait_n(4);
    // R5: DVI holds the packet domain only
    dvi_mode = 1'b1; wait_n(6);
    chk("R5", "pkt_rst during DVI", pkt_rst, 1'b1);
    chk("R5", "hdmi_rst free during DVI", hdmi_rst, 1'b0);
    dvi_mode = 1'b0; wait_n(10);
    // R7/R9: port changes, invalid code 5, then D
    port_sel = 3'd2; wait_n(8);
    port_sel = 3'd5; wait_n(6);
    chk("R9", "invalid select holds reset", hdmi_rst, 1'b1);
    port_sel = 3'd3; wait_n(10);
    // R7: TMDS clock returns on port D
    tmds_act[3] = 1'b0; wait_n(5); tmds_act[3] = 1'b1; wait_n(10);
    // R8: back-to-back triggers merge
    port_sel = 3'd1; wait_n(1); port_sel = 3'd0; wait_n(1); port_sel = 3'd2; wait_n(10);
    // R6: software bit and supply dropout
    edid_sw_rst = 1'b1; wait_n(1); edid_sw_rst = 1'b0; wait_n(10);
    supply_good = 1'b0; wait_n(4); supply_good = 1'b1; wait_n(12);
    // R1: chip reset mid-run
    pull_chip_reset(5); wait_n(12);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if ($urandom_range(7) == 0)  tmds_act[$urandom_range(NP-1)] ^= 1'b1;
      if ($urandom_range(9) == 0)  cable_5v[$urandom_range(NP-1)] ^= 1'b1;
      if ($urandom_range(39) == 0) port_sel = ($urandom_range(9) == 0) ?
                                     SW'($urandom_range(7, 4)) : SW'($urandom_range(3));
      if ($urandom_range(29) == 0) dvi_mode = ~dvi_mode;
      if ($urandom_range(49) == 0) cable_rst_dis = ~cable_rst_dis;
      edid_sw_rst = ($urandom_range(59) == 0);
      if ($urandom_range(199) == 0) supply_good = ~supply_good;
      if ($urandom_range(299) == 0) chip_rst_n = 1'b0;
      else if (!chip_rst_n && $urandom_range(3) == 0) chip_rst_n = 1'b1;
    end
    chip_rst_n = 1'b1;
    wait_n(4);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule